// File: doc/BRIEF.md
# Serial Configuration Load Sequencer

This block sits on the host side of a device that takes its configuration as a serial bit stream. On a start request it pulses an active-low program-reset line. It waits for the target's init status to pass through its low phase and come back high. It then generates a configuration clock by dividing the system clock, and shifts bytes from a ready/valid byte stream onto one data line, most significant bit first. The target's mode-select pins are held at the value that selects slave serial loading.

The byte stream marks its final byte with a last flag. Reaching that byte does not finish the run. The clock keeps toggling after the last data bit until the target raises its done status, which ends the run with success. If init drops during loading or the trailing clocks, the run ends with an error. Two timeouts also end a run, each with a separate timeout status: one bounds the wait for init, the other bounds the trailing clocks. The three result flags keep their value until the next accepted start.

Top module: `cfg_serial_loader`

## Requirements
- R1: An accepted start drives `progN` low for exactly PROG_WIDTH system clock cycles, once per run.
- R2: No configuration clock rising edge occurs until `initIn` has been seen low (during or after the reset pulse) and then high. If this does not happen within INIT_TIMEOUT cycles after the pulse ends, the run ends with `runTimeout`=1 and no clock edges. This also applies when init never goes low.
- R3: Byte bits appear on `cfgData` most significant bit first, one bit per `cfgClk` rising edge. `cfgData` never changes while `cfgClk` stays high.
- R4: While running, `cfgClk` has a period of 2*DIV_HALF system cycles within a byte. It is low whenever no run is loading.
- R5: A byte is accepted (`inValid` and `inReady` both 1 at a clock edge) only after all 8 bits of the previous byte have been clocked, so the k-th accepted byte (from 0) is taken after exactly 8*k rising edges. The clock pauses low while no byte is available.
- R6: After the byte flagged with `inLast`, the clock keeps running. `doneIn`=1 ends the run with `runOk`=1, and exactly as many rising edges are produced as the target needed.
- R7: `initIn` going low while loading or trailing ends the run with `runErr`=1 and stops the clock.
- R8: If `doneIn` stays low for TAIL_TIMEOUT rising edges after the last data bit, the run ends with `runTimeout`=1 after exactly 8*bytes+TAIL_TIMEOUT rising edges. `doneIn` arriving on the final allowed edge still counts as success.
- R9: `start` is ignored while `busy`=1.
- R10: At most one of `runOk`, `runErr` and `runTimeout` is 1. All three are 0 while busy, and they hold after the run until the next start.
- R11: `modeSel` is always 3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a configuration run |
| inByte | input | 8 | Stream byte |
| inValid | input | 1 | Stream byte valid |
| inLast | input | 1 | Marks the final stream byte |
| inReady | output | 1 | Sequencer takes the byte at this edge |
| initIn | input | 1 | Target init status |
| doneIn | input | 1 | Target done status |
| progN | output | 1 | Active-low program-reset to the target |
| cfgClk | output | 1 | Generated configuration clock |
| cfgData | output | 1 | Serial configuration data |
| modeSel | output | 3 | Target mode-select drive |
| busy | output | 1 | Run in progress |
| runOk | output | 1 | Last run succeeded |
| runErr | output | 1 | Last run ended by init low |
| runTimeout | output | 1 | Last run ended by a timeout |

## Verification
If the bit counter or shifter is in a wrong state, the bytes rebuilt at the target from the `cfgClk` edges come out wrong by the end of the first byte. The byte handshake then arrives at a rise count that is not a multiple of eight. A wrong divider count shows up on the next rising edge as a period other than 2*DIV_HALF cycles. A wrong control state shows up within one run, in one of several ways: the reset pulse has the wrong width, clock edges appear before init has cycled, the total rise count differs from the target's need, or the wrong result flag is set when `busy` falls.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_WAITI,
    ST_LOAD,
    ST_TAIL
  } seqStateT;

  typedef struct packed {
    logic clear;
    logic run;
    logic feed;
  } dpCtlT;
endpackage

// File: rtl/cfgl_datapath.sv
module cfgl_datapath
  import cfgl_pkg::*;
#(
  parameter int DIV_HALF     = 2,
  parameter int TAIL_TIMEOUT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCtlT      ctl,
  input  logic [7:0] inByte,
  input  logic       inValid,
  input  logic       inLast,
  output logic       inReady,
  output logic       cfgClk,
  output logic       cfgData,
  output logic       dataDone,
  output logic       tailOver
);
  localparam int DW = $clog2(DIV_HALF + 1);
  localparam int TW = $clog2(TAIL_TIMEOUT + 1);

  logic [DW-1:0] divCnt;
  logic          cfgClkR;
  logic [7:0]    shReg;
  logic [2:0]    bitCnt;
  logic          haveByte;
  logic          lastByte;
  logic          doneR;
  logic [TW-1:0] riseCnt;

  logic clkGo, tick, riseT, fallT, take;

  assign clkGo   = ctl.run && (ctl.feed ? haveByte : 1'b1);
  assign tick    = clkGo && (divCnt == DW'(DIV_HALF - 1));
  assign riseT   = tick && !cfgClkR;
  assign fallT   = tick && cfgClkR;
  assign inReady = ctl.feed && !haveByte && !doneR && !cfgClkR;
  assign take    = inReady && inValid;

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clear) begin
      divCnt   <= '0;
      cfgClkR  <= 1'b0;
      shReg    <= '0;
      bitCnt   <= '0;
      haveByte <= 1'b0;
      lastByte <= 1'b0;
      doneR    <= 1'b0;
      riseCnt  <= '0;
    end else begin
      if (!clkGo || tick) divCnt <= '0;
      else divCnt <= divCnt + 1'b1;

      if (!ctl.run) cfgClkR <= 1'b0;
      else if (tick) cfgClkR <= ~cfgClkR;

      if (take) begin
        shReg    <= inByte;
        bitCnt   <= '0;
        haveByte <= 1'b1;
        lastByte <= inLast;
      end else if (ctl.feed && fallT) begin
        if (bitCnt == 3'd7) begin
          haveByte <= 1'b0;
          if (lastByte) doneR <= 1'b1;
        end else begin
          shReg  <= {shReg[6:0], 1'b0};
          bitCnt <= bitCnt + 1'b1;
        end
      end

      if (!ctl.feed && riseT && riseCnt != TW'(TAIL_TIMEOUT))
        riseCnt <= riseCnt + 1'b1;
    end
  end

  assign cfgClk   = cfgClkR;
  assign cfgData  = shReg[7];
  assign dataDone = doneR;
  assign tailOver = (riseCnt == TW'(TAIL_TIMEOUT));

  a_r4_idle_clock_low: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.run |=> !cfgClkR);

  a_r3_data_held_high: assert property (@(posedge clk) disable iff (!rstN)
    (cfgClkR && $past(cfgClkR)) |-> $stable(cfgData));

  a_r3_data_held_at_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgClkR) |-> $stable(cfgData));

  a_r5_take_restarts_byte: assert property (@(posedge clk) disable iff (!rstN)
    (take && !ctl.clear) |=> (haveByte && !cfgClkR && bitCnt == 3'd0));

  a_r8_tail_bounded: assert property (@(posedge clk) disable iff (!rstN)
    riseCnt <= TW'(TAIL_TIMEOUT));
endmodule

// File: rtl/cfgl_ctrl.sv
module cfgl_ctrl
  import cfgl_pkg::*;
#(
  parameter int PROG_WIDTH   = 8,
  parameter int INIT_TIMEOUT = 40
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  start,
  input  logic  initIn,
  input  logic  doneIn,
  input  logic  dataDone,
  input  logic  tailOver,
  output dpCtlT ctl,
  output logic  progN,
  output logic  busy,
  output logic  runOk,
  output logic  runErr,
  output logic  runTimeout
);
  localparam int CMAX = (PROG_WIDTH > INIT_TIMEOUT) ? PROG_WIDTH : INIT_TIMEOUT;
  localparam int CW   = $clog2(CMAX + 1);

  seqStateT      state;
  logic [CW-1:0] cnt;
  logic          initSeenLow;
  logic          okR, errR, toR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      initSeenLow <= 1'b0;
      okR         <= 1'b0;
      errR        <= 1'b0;
      toR         <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state       <= ST_PROG;
            cnt         <= '0;
            initSeenLow <= 1'b0;
            okR         <= 1'b0;
            errR        <= 1'b0;
            toR         <= 1'b0;
          end
        end
        ST_PROG: begin
          if (!initIn) initSeenLow <= 1'b1;
          if (cnt == CW'(PROG_WIDTH - 1)) begin
            state <= ST_WAITI;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WAITI: begin
          if (initSeenLow && initIn) begin
            state <= ST_LOAD;
          end else begin
            if (!initIn) initSeenLow <= 1'b1;
            if (cnt == CW'(INIT_TIMEOUT - 1)) begin
              state <= ST_IDLE;
              toR   <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_LOAD: begin
          if (!initIn) begin
            state <= ST_IDLE;
            errR  <= 1'b1;
          end else if (doneIn) begin
            state <= ST_IDLE;
            okR   <= 1'b1;
          end else if (dataDone) begin
            state <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          if (!initIn) begin
            state <= ST_IDLE;
            errR  <= 1'b1;
          end else if (doneIn) begin
            state <= ST_IDLE;
            okR   <= 1'b1;
          end else if (tailOver) begin
            state <= ST_IDLE;
            toR   <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.clear = (state == ST_IDLE);
    ctl.run   = (state == ST_LOAD) || (state == ST_TAIL);
    ctl.feed  = (state == ST_LOAD);
  end

  assign progN      = (state != ST_PROG);
  assign busy       = (state != ST_IDLE);
  assign runOk      = okR;
  assign runErr     = errR;
  assign runTimeout = toR;

  a_r10_one_result: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({runOk, runErr, runTimeout}));

  a_r10_clear_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(runOk || runErr || runTimeout));

  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> !$fell(progN));

  a_r2_load_needs_init: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOAD && $past(state == ST_WAITI)) |-> ($past(initIn) && $past(initSeenLow)));
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfgl_pkg::*;
#(
  parameter int DIV_HALF     = 2,
  parameter int PROG_WIDTH   = 8,
  parameter int INIT_TIMEOUT = 40,
  parameter int TAIL_TIMEOUT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [7:0] inByte,
  input  logic       inValid,
  input  logic       inLast,
  output logic       inReady,
  input  logic       initIn,
  input  logic       doneIn,
  output logic       progN,
  output logic       cfgClk,
  output logic       cfgData,
  output logic [2:0] modeSel,
  output logic       busy,
  output logic       runOk,
  output logic       runErr,
  output logic       runTimeout
);
  dpCtlT ctl;
  logic  dataDone;
  logic  tailOver;

  cfgl_ctrl #(
    .PROG_WIDTH  (PROG_WIDTH),
    .INIT_TIMEOUT(INIT_TIMEOUT)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .initIn    (initIn),
    .doneIn    (doneIn),
    .dataDone  (dataDone),
    .tailOver  (tailOver),
    .ctl       (ctl),
    .progN     (progN),
    .busy      (busy),
    .runOk     (runOk),
    .runErr    (runErr),
    .runTimeout(runTimeout)
  );

  cfgl_datapath #(
    .DIV_HALF    (DIV_HALF),
    .TAIL_TIMEOUT(TAIL_TIMEOUT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .inByte  (inByte),
    .inValid (inValid),
    .inLast  (inLast),
    .inReady (inReady),
    .cfgClk  (cfgClk),
    .cfgData (cfgData),
    .dataDone(dataDone),
    .tailOver(tailOver)
  );

  assign modeSel = 3'b111;
endmodule

// File: tb/sim_cfg_serial_loader.sv
`timescale 1ns/1ps
module sim_cfg_serial_loader;
  localparam int DIV_HALF = 2;
  localparam int PW       = 8;
  localparam int INIT_TO  = 40;
  localparam int TAIL_TO  = 16;
  localparam real CLK_NS  = 4.0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [7:0] inByte = 8'h00;
  logic inValid = 1'b0, inLast = 1'b0, inReady;
  logic initIn = 1'b1, doneIn = 1'b0;
  logic progN, cfgClk, cfgData, busy, runOk, runErr, runTimeout;
  logic [2:0] modeSel;

  always #2 clk = ~clk;

  cfg_serial_loader #(.DIV_HALF(DIV_HALF), .PROG_WIDTH(PW),
                      .INIT_TIMEOUT(INIT_TO), .TAIL_TIMEOUT(TAIL_TO)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .inByte(inByte), .inValid(inValid),
    .inLast(inLast), .inReady(inReady), .initIn(initIn), .doneIn(doneIn),
    .progN(progN), .cfgClk(cfgClk), .cfgData(cfgData), .modeSel(modeSel),
    .busy(busy), .runOk(runOk), .runErr(runErr), .runTimeout(runTimeout));

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic chk(bit cond, string req, string what, int act, int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Target model: counts rising edges and rebuilds bytes
  int rises = 0, bitPos = 0, nCapt = 0, periodBad = 0;
  logic [7:0] capSh = 8'h00;
  logic [7:0] capt [0:15];
  realtime lastRise = 0;
  always @(posedge cfgClk) begin
    capSh = {capSh[6:0], cfgData};
    if (bitPos != 0 && ($realtime - lastRise) != 2.0 * DIV_HALF * CLK_NS) periodBad++;
    lastRise = $realtime;
    rises++;
    bitPos++;
    if (bitPos == 8) begin
      if (nCapt < 16) capt[nCapt] = capSh;
      nCapt++;
      bitPos = 0;
    end
  end

  int progFalls = 0;
  always @(negedge progN) progFalls++;

  // Byte source and data-stability monitor, all at the falling system edge
  logic [7:0] txB [0:15];
  int txN = 0, txIdx = 0, gapCfg = 0, gapLeft = 0, hsBad = 0, dataBad = 0;
  bit pend = 1'b0;
  logic prevClk = 1'b0, prevData = 1'b0;
  always @(negedge clk) begin
    if (prevClk && cfgClk && (cfgData != prevData)) dataBad++;
    prevClk = cfgClk;
    prevData = cfgData;
    if (pend) begin
      txIdx++;
      gapLeft = gapCfg;
    end
    if (txIdx < txN && gapLeft == 0) begin
      inValid = 1'b1;
      inByte  = txB[txIdx];
      inLast  = (txIdx == txN - 1);
    end else begin
      inValid = 1'b0;
      if (gapLeft > 0) gapLeft--;
    end
    pend = inValid && inReady;
    if (pend && rises != 8 * txIdx) hsBad++;
  end

  // mode: 0 done after need edges, 1 init stuck low, 2 init drops, 3 no done, 4 init never low
  task automatic runCfg(int n, int gap, int dly, int extra, int mode, int dropAt, bit midStart);
    int progLow, cyc, need, fallsBefore;
    logic sOk, sErr, sTo;
    rises = 0; bitPos = 0; nCapt = 0; periodBad = 0; hsBad = 0; dataBad = 0;
    for (int i = 0; i < n; i++) txB[i] = 8'((n * 53 + gap * 17 + extra * 29 + i * 101 + 165) & 255);
    txIdx = 0; gapCfg = gap; gapLeft = 0; pend = 1'b0; txN = n;
    doneIn = 1'b0; initIn = 1'b1;
    need = 8 * n + extra;
    fallsBefore = progFalls;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    progLow = 0;
    while (!progN && progLow < 1000) begin
      progLow++;
      if (mode != 4) initIn = 1'b0;
      @(negedge clk);
    end
    chk(progLow == PW, "R1", "program pulse width", progLow, PW);
    cyc = 0;
    repeat (dly) begin
      cyc++;
      @(negedge clk);
    end
    if (mode == 0 || mode == 2 || mode == 3) initIn = 1'b1;
    while (busy && cyc < 5000) begin
      start = (midStart && rises == 3) ? 1'b1 : 1'b0;
      if (mode == 0 && rises >= need) doneIn = 1'b1;
      if (mode == 2 && rises >= dropAt) initIn = 1'b0;
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(progFalls - fallsBefore == 1, "R9", "program pulses per run", progFalls - fallsBefore, 1);
    chk(!busy, "R10", "run ended", busy, 0);
    case (mode)
      0: begin
        chk(runOk && !runErr && !runTimeout, "R6", "success flag", {runOk, runErr, runTimeout}, 4);
        chk(rises == need, "R6", "total rising edges", rises, need);
        for (int i = 0; i < n; i++)
          chk(capt[i] == txB[i], "R3", "captured byte", capt[i], txB[i]);
        chk(periodBad == 0, "R4", "clock period faults", periodBad, 0);
        chk(dataBad == 0, "R3", "data change while clock high", dataBad, 0);
        chk(hsBad == 0, "R5", "handshake off byte boundary", hsBad, 0);
        chk(txIdx == n, "R5", "bytes taken", txIdx, n);
      end
      1: begin
        chk(runTimeout && !runOk && !runErr, "R2", "init wait timeout flag", {runOk, runErr, runTimeout}, 1);
        chk(rises == 0, "R2", "no clock before init", rises, 0);
        chk(cyc == INIT_TO, "R2", "init wait length", cyc, INIT_TO);
      end
      2: begin
        chk(runErr && !runOk && !runTimeout, "R7", "error flag", {runOk, runErr, runTimeout}, 2);
        chk(rises == dropAt, "R7", "clock stops on init low", rises, dropAt);
      end
      3: begin
        chk(runTimeout && !runOk && !runErr, "R8", "tail timeout flag", {runOk, runErr, runTimeout}, 1);
        chk(rises == 8 * n + TAIL_TO, "R8", "edges before tail timeout", rises, 8 * n + TAIL_TO);
      end
      default: begin
        chk(runTimeout && !runOk && !runErr, "R2", "timeout when init never low", {runOk, runErr, runTimeout}, 1);
        chk(rises == 0, "R2", "no clock without init low", rises, 0);
      end
    endcase
    sOk = runOk; sErr = runErr; sTo = runTimeout;
    doneIn = 1'b0;
    repeat (7) @(negedge clk);
    chk({runOk, runErr, runTimeout} == {sOk, sErr, sTo}, "R10", "flags hold",
        {runOk, runErr, runTimeout}, {sOk, sErr, sTo});
    chk(!cfgClk, "R4", "clock low when idle", cfgClk, 0);
    chk(modeSel == 3'b111, "R11", "mode select", modeSel, 7);
    initIn = 1'b1;
  endtask

  int cycCount = 0;
  always @(posedge clk) begin
    cycCount++;
    if (cycCount > 190000 && !finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycCount, 190000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int extras [4];
    extras[0] = 0; extras[1] = 1; extras[2] = 3; extras[3] = TAIL_TO;
    repeat (4) @(negedge clk);
    chk(progN == 1'b1, "R1", "reset progN", progN, 1);
    chk(cfgClk == 1'b0, "R4", "reset clock", cfgClk, 0);
    chk(busy == 1'b0, "R10", "reset busy", busy, 0);
    chk({runOk, runErr, runTimeout} == 3'b000, "R10", "reset flags", {runOk, runErr, runTimeout}, 0);
    chk(inReady == 1'b0, "R5", "reset ready", inReady, 0);
    chk(modeSel == 3'b111, "R11", "reset mode select", modeSel, 7);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    for (int n = 1; n <= 3; n++)
      for (int g = 0; g <= 2; g++)
        for (int e = 0; e < 4; e++)
          for (int d = 0; d <= 7; d += 7)
            runCfg(n, g, d, extras[e], 0, 0, (n == 2 && g == 1));
    runCfg(2, 0, 0, 0, 1, 0, 1'b0);
    runCfg(2, 1, 3, 0, 2, 5, 1'b0);
    runCfg(3, 0, 2, 0, 2, 20, 1'b0);
    runCfg(1, 0, 0, 0, 3, 0, 1'b0);
    runCfg(3, 2, 4, 0, 3, 0, 1'b0);
    runCfg(1, 0, 0, 0, 4, 0, 1'b0);
    runCfg(1, 0, 0, 2, 0, 0, 1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule